// File: doc/BRIEF.md
# PLL Reprogramming Sequencer

This block changes the divisor settings of one phase-locked loop without ever letting the downstream clock tree see the loop while it is out of lock. A client presents a request with three raw divisor values: the reference divider, the feedback multiplier and the output divider. The block first checks that the request is legal. A legal request is applied as a fixed sequence. The clock mux is steered to the bypass oscillator. The loop is then put in reset and the minus-one encoded divisor and bandwidth fields are written. After a settle time the reset is released. The block waits for the synchronised lock indication and, only then, steers the mux back to the loop output.

An illegal request is answered at once with an acknowledge and an error flag, and nothing at the outputs changes. If lock does not arrive within a parameterised number of cycles, the sequence ends with an error acknowledge and the mux is left on the bypass source. The analog loop and any register file that feeds the request port sit outside the block.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, `pll_mode` is 0 (bypass), `pll_cfg_div`, `pll_cfg_fb`, `pll_cfg_bw` and `pll_cfg_ctl` are all zero, and `req_ack` and `req_busy` are low.
- R2: On a legal request sampled at clock edge k, `pll_mode` becomes 0 after edge k. Reset (`pll_cfg_ctl` bit 5) becomes 1 after edge k+1. The divisor and bandwidth words take their new values after edge k+2, while the reset bit is already high. Reset is never high while `pll_mode` is 1.
- R3: The encodings are as follows. `pll_cfg_div[13:8]` = NR-1 and `pll_cfg_div[3:0]` = NO-1, with all other bits 0. `pll_cfg_fb` = NF-1. `pll_cfg_bw` = floor(NF/2)-1.
- R4: The reset bit falls exactly SETTLE_CYC cycles after the cycle in which the divisor words change.
- R5: Lock passes through two synchronising flops. The cycle the FSM sees it, `pll_mode` becomes 1 and `req_ack` pulses with `req_err` low. This gives an acknowledge three clock edges after `pll_lock` rises (first edge sampling it high counted as one).
- R6: A request is legal only if all of these hold: 1 ≤ NR ≤ 64; 2 ≤ NF ≤ 8192; 1 ≤ NO ≤ 16; NO is 1 or even; 440000·NR ≤ REF_KHZ·NF ≤ 2200000·NR; and 27500·NR·NO ≤ REF_KHZ·NF ≤ 2200000·NR·NO.
- R7: An illegal request gives `req_ack` and `req_err` high for one cycle right after the sampling edge. No other output changes.
- R8: If lock is not seen within LOCK_TMO cycles of the reset release, `req_ack` and `req_err` pulse. `pll_mode` stays 0, the reset bit stays 0 and the new divisor words stay in place.
- R9: `req_busy` is high from the edge that accepts a legal request until the acknowledge. Any `req_valid` seen while busy is ignored.
- R10: `req_ack` is a single-cycle pulse, and `req_err` is only ever high together with `req_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_ref_div | input | NR_W+1 | Raw reference divider NR |
| req_fb_mul | input | NF_W+1 | Raw feedback multiplier NF |
| req_out_div | input | NO_W+1 | Raw output divider NO |
| req_busy | output | 1 | Sequence in progress |
| req_ack | output | 1 | One-cycle completion pulse |
| req_err | output | 1 | Error qualifier of the acknowledge |
| pll_cfg_div | output | 16 | Word with the NR-1 and NO-1 fields |
| pll_cfg_fb | output | NF_W | NF-1 |
| pll_cfg_bw | output | BW_W | Bandwidth-adjust field |
| pll_cfg_ctl | output | 16 | Control word, loop reset at bit 5 |
| pll_mode | output | 2 | Mux select: 0 bypass, 1 loop output |
| pll_lock | input | 1 | Asynchronous lock indication |

## Verification
Index each stimulus by the number of clock edges since the edge that sampled `req_valid`, counting that edge as 1. The expected outputs then fall on fixed cycles:
- Illegal acknowledge: cycle 1.
- Bypass: after cycle 1.
- Reset: after cycle 2.
- Divisor words: after cycle 3.
- Reset release: after cycle 3+SETTLE_CYC.
- Timeout acknowledge: cycle 3+SETTLE_CYC+LOCK_TMO.

The bench lock model raises lock a fixed delay after release. A legal acknowledge therefore falls three edges after that rise. Every output is sampled on the falling edge following the rising edge that should have updated it. Each latency is compared as an exact cycle count, not waited on loosely.

// File: rtl/pll_reprog_pkg.sv
package pll_reprog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HOLD,
    ST_LOAD,
    ST_SETTLE,
    ST_LOCKW
  } seq_state_t;

  localparam logic [1:0] MODE_BYPASS = 2'd0;
  localparam logic [1:0] MODE_RUN    = 2'd1;

  localparam int DIV_WORD_W = 16;
  localparam int CTL_WORD_W = 16;
  localparam int NR_LSB     = 8;
  localparam int RST_BIT    = 5;

endpackage

// File: rtl/pll_div_check.sv
module pll_div_check #(
  parameter int          NR_W    = 6,
  parameter int          NF_W    = 13,
  parameter int          NO_W    = 4,
  parameter int          BW_W    = 12,
  parameter int unsigned REF_KHZ = 24000,
  parameter int unsigned VCO_MIN = 440000,
  parameter int unsigned VCO_MAX = 2200000,
  parameter int unsigned OUT_MIN = 27500,
  parameter int unsigned OUT_MAX = 2200000
) (
  input  logic [NR_W:0]   nr,
  input  logic [NF_W:0]   nf,
  input  logic [NO_W:0]   no,
  output logic            legal,
  output logic [NR_W-1:0] nr_enc,
  output logic [NF_W-1:0] nf_enc,
  output logic [NO_W-1:0] no_enc,
  output logic [BW_W-1:0] bw_enc
);
  localparam int PW = 48;

  logic [PW-1:0] nr_w, nf_w, no_w, ref_nf;
  logic [PW-1:0] lo_vco, hi_vco, lo_out, hi_out;
  logic          range_ok, parity_ok;

  // Products replace the divisions of the frequency rules.
  always_comb begin
    nr_w      = PW'(nr);
    nf_w      = PW'(nf);
    no_w      = PW'(no);
    ref_nf    = PW'(REF_KHZ) * nf_w;
    lo_vco    = PW'(VCO_MIN) * nr_w;
    hi_vco    = PW'(VCO_MAX) * nr_w;
    lo_out    = PW'(OUT_MIN) * nr_w * no_w;
    hi_out    = PW'(OUT_MAX) * nr_w * no_w;
    range_ok  = (nr_w >= PW'(1)) && (nr_w <= (PW'(1) << NR_W)) &&
                (nf_w >= PW'(2)) && (nf_w <= (PW'(1) << NF_W)) &&
                (no_w >= PW'(1)) && (no_w <= (PW'(1) << NO_W));
    parity_ok = (no_w == PW'(1)) || !no[0];
    legal     = range_ok && parity_ok &&
                (ref_nf >= lo_vco) && (ref_nf <= hi_vco) &&
                (ref_nf >= lo_out) && (ref_nf <= hi_out);
    nr_enc    = NR_W'(nr - 1'b1);
    nf_enc    = NF_W'(nf - 1'b1);
    no_enc    = NO_W'(no - 1'b1);
    bw_enc    = BW_W'((nf >> 1) - 1'b1);
  end

endmodule

// File: rtl/pll_lock_sync.sv
module pll_lock_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_async,
  output logic lock_sync
);
  logic s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= 1'b0;
      s2_q <= 1'b0;
    end else begin
      s1_q <= lock_async;
      s2_q <= s1_q;
    end
  end

  assign lock_sync = s2_q;

endmodule

// File: rtl/pll_seq_timer.sv
module pll_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             en,
  input  logic [CNT_W-1:0] limit,
  output logic             hit
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)     cnt_d = '0;
    else if (en) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else if (clr || en) cnt_q <= cnt_d;
  end

  assign hit = (cnt_q == limit - 1'b1);

  // R4 / R8: a running window never passes its terminal count
  a_r4_cnt_in_window: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !clr) |-> (cnt_q < limit));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
  import pll_reprog_pkg::*;
#(
  parameter int          NR_W       = 6,
  parameter int          NF_W       = 13,
  parameter int          NO_W       = 4,
  parameter int          BW_W       = 12,
  parameter int unsigned REF_KHZ    = 24000,
  parameter int unsigned SETTLE_CYC = 240,
  parameter int unsigned LOCK_TMO   = 24000
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [NR_W:0]         req_ref_div,
  input  logic [NF_W:0]         req_fb_mul,
  input  logic [NO_W:0]         req_out_div,
  output logic                  req_busy,
  output logic                  req_ack,
  output logic                  req_err,
  output logic [DIV_WORD_W-1:0] pll_cfg_div,
  output logic [NF_W-1:0]       pll_cfg_fb,
  output logic [BW_W-1:0]       pll_cfg_bw,
  output logic [CTL_WORD_W-1:0] pll_cfg_ctl,
  output logic [1:0]            pll_mode,
  input  logic                  pll_lock
);
  localparam int unsigned WIN_MAX = (SETTLE_CYC > LOCK_TMO) ? SETTLE_CYC : LOCK_TMO;
  localparam int          CNT_W   = $clog2(WIN_MAX + 1);

  seq_state_t            state_q, state_d;
  logic [1:0]            mode_q, mode_d;
  logic                  rst_q, rst_d;
  logic                  ack_q, ack_d, err_q, err_d;
  logic [DIV_WORD_W-1:0] div_q, div_d;
  logic [NF_W-1:0]       fb_q, fb_d;
  logic [BW_W-1:0]       bw_q, bw_d;
  logic [NR_W-1:0]       nr_q;
  logic [NF_W-1:0]       nf_q;
  logic [NO_W-1:0]       no_q;
  logic [BW_W-1:0]       bwv_q;

  logic                  legal, accept, lock_s;
  logic [NR_W-1:0]       nr_enc;
  logic [NF_W-1:0]       nf_enc;
  logic [NO_W-1:0]       no_enc;
  logic [BW_W-1:0]       bw_enc;
  logic                  tmr_clr, tmr_en, tmr_hit;
  logic [CNT_W-1:0]      tmr_limit;

  pll_div_check #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W), .REF_KHZ(REF_KHZ)
  ) u_check (
    .nr(req_ref_div), .nf(req_fb_mul), .no(req_out_div), .legal(legal),
    .nr_enc(nr_enc), .nf_enc(nf_enc), .no_enc(no_enc), .bw_enc(bw_enc)
  );

  pll_lock_sync u_sync (
    .clk(clk), .rst_n(rst_n), .lock_async(pll_lock), .lock_sync(lock_s)
  );

  assign tmr_limit = (state_q == ST_SETTLE) ? CNT_W'(SETTLE_CYC) : CNT_W'(LOCK_TMO);

  pll_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .en(tmr_en),
    .limit(tmr_limit), .hit(tmr_hit)
  );

  assign accept = (state_q == ST_IDLE) && req_valid && legal;

  // Next-state logic
  always_comb begin
    state_d = state_q;
    mode_d  = mode_q;
    rst_d   = rst_q;
    div_d   = div_q;
    fb_d    = fb_q;
    bw_d    = bw_q;
    ack_d   = 1'b0;
    err_d   = 1'b0;
    tmr_clr = 1'b0;
    tmr_en  = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (legal) begin
            mode_d  = MODE_BYPASS;
            state_d = ST_HOLD;
          end else begin
            ack_d = 1'b1;
            err_d = 1'b1;
          end
        end
      end
      ST_HOLD: begin
        rst_d   = 1'b1;
        state_d = ST_LOAD;
      end
      ST_LOAD: begin
        div_d                   = '0;
        div_d[NR_LSB +: NR_W]   = nr_q;
        div_d[NO_W-1:0]         = no_q;
        fb_d                    = nf_q;
        bw_d                    = bwv_q;
        tmr_clr                 = 1'b1;
        state_d                 = ST_SETTLE;
      end
      ST_SETTLE: begin
        tmr_en = 1'b1;
        if (tmr_hit) begin
          rst_d   = 1'b0;
          tmr_clr = 1'b1;
          state_d = ST_LOCKW;
        end
      end
      ST_LOCKW: begin
        tmr_en = 1'b1;
        if (lock_s) begin
          mode_d  = MODE_RUN;
          ack_d   = 1'b1;
          state_d = ST_IDLE;
        end else if (tmr_hit) begin
          ack_d   = 1'b1;
          err_d   = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      mode_q  <= MODE_BYPASS;
      rst_q   <= 1'b0;
      ack_q   <= 1'b0;
      err_q   <= 1'b0;
      div_q   <= '0;
      fb_q    <= '0;
      bw_q    <= '0;
      nr_q    <= '0;
      nf_q    <= '0;
      no_q    <= '0;
      bwv_q   <= '0;
    end else begin
      state_q <= state_d;
      mode_q  <= mode_d;
      rst_q   <= rst_d;
      ack_q   <= ack_d;
      err_q   <= err_d;
      if (state_q == ST_LOAD) begin
        div_q <= div_d;
        fb_q  <= fb_d;
        bw_q  <= bw_d;
      end
      if (accept) begin
        nr_q  <= nr_enc;
        nf_q  <= nf_enc;
        no_q  <= no_enc;
        bwv_q <= bw_enc;
      end
    end
  end

  assign req_busy    = (state_q != ST_IDLE);
  assign req_ack     = ack_q;
  assign req_err     = err_q;
  assign pll_cfg_div = div_q;
  assign pll_cfg_fb  = fb_q;
  assign pll_cfg_bw  = bw_q;
  assign pll_cfg_ctl = CTL_WORD_W'(rst_q) << RST_BIT;
  assign pll_mode    = mode_q;

  a_r2_reset_only_bypassed: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_ctl[RST_BIT] |-> (pll_mode == MODE_BYPASS));

  a_r2_fields_under_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable({pll_cfg_div, pll_cfg_fb, pll_cfg_bw}) |-> pll_cfg_ctl[RST_BIT]);

  a_r5_run_after_lock: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_mode == MODE_RUN) |-> $past(lock_s));

  a_r5_good_ack_running: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && !req_err) |-> (pll_mode == MODE_RUN));

  a_r7_reject_keeps_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ack && req_err && $past(state_q == ST_IDLE)) |-> $stable(pll_mode));

  a_r9_idle_at_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |-> !req_busy);

  a_r10_ack_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_ack |=> !req_ack);

  a_r10_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
    req_err |-> req_ack);

endmodule

// File: tb/pll_reprog_seq_bench.sv
module pll_reprog_seq_bench;
  localparam int NR_W     = 6;
  localparam int NF_W     = 13;
  localparam int NO_W     = 4;
  localparam int BW_W     = 12;
  localparam int REF      = 24000;
  localparam int SETTLE   = 8;
  localparam int TMO      = 20;
  localparam int LOCK_DLY = 4;
  localparam int LAT_OK   = SETTLE + LOCK_DLY + 6;
  localparam int LAT_TMO  = SETTLE + TMO + 3;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid;
  logic [NR_W:0] req_ref_div;
  logic [NF_W:0] req_fb_mul;
  logic [NO_W:0] req_out_div;
  logic req_busy, req_ack, req_err;
  logic [15:0] pll_cfg_div;
  logic [NF_W-1:0] pll_cfg_fb;
  logic [BW_W-1:0] pll_cfg_bw;
  logic [15:0] pll_cfg_ctl;
  logic [1:0] pll_mode;
  logic pll_lock;

  int n_total = 0;
  int n_fail  = 0;
  bit finished = 1'b0;
  bit lock_dead = 1'b0;
  int lcnt = 0;

  always #5 clk = ~clk;

  pll_reprog_seq #(
    .NR_W(NR_W), .NF_W(NF_W), .NO_W(NO_W), .BW_W(BW_W),
    .REF_KHZ(REF), .SETTLE_CYC(SETTLE), .LOCK_TMO(TMO)
  ) u_pll_reprog_seq (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid),
    .req_ref_div(req_ref_div), .req_fb_mul(req_fb_mul), .req_out_div(req_out_div),
    .req_busy(req_busy), .req_ack(req_ack), .req_err(req_err),
    .pll_cfg_div(pll_cfg_div), .pll_cfg_fb(pll_cfg_fb), .pll_cfg_bw(pll_cfg_bw),
    .pll_cfg_ctl(pll_cfg_ctl), .pll_mode(pll_mode), .pll_lock(pll_lock)
  );

  // Lock model: low while in reset, rises LOCK_DLY+1 falling edges after release.
  always @(negedge clk) begin
    if (!rst_n || pll_cfg_ctl[5]) begin
      pll_lock = 1'b0;
      lcnt = 0;
    end else if (!lock_dead) begin
      if (lcnt == LOCK_DLY) pll_lock = 1'b1;
      else lcnt = lcnt + 1;
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    n_total++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit legal_exp(input longint nr, input longint nf, input longint no);
    longint p;
    p = REF * nf;
    if (nr < 1 || nr > 64 || nf < 2 || nf > 8192 || no < 1 || no > 16) return 1'b0;
    if (no != 1 && (no % 2) != 0) return 1'b0;
    if (p < 440000 * nr || p > 2200000 * nr) return 1'b0;
    if (p < 27500 * nr * no || p > 2200000 * nr * no) return 1'b0;
    return 1'b1;
  endfunction

  task automatic issue(input int nr, input int nf, input int no);
    @(negedge clk);
    req_valid   = 1'b1;
    req_ref_div = (NR_W+1)'(nr);
    req_fb_mul  = (NF_W+1)'(nf);
    req_out_div = (NO_W+1)'(no);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wait_ack(inout int n);
    while (!req_ack && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic run_check(input int nr, input int nf, input int no);
    longint old_div, old_fb, old_bw, old_mode;
    bit lg;
    int n;
    old_div = pll_cfg_div; old_fb = pll_cfg_fb; old_bw = pll_cfg_bw; old_mode = pll_mode;
    lg = legal_exp(nr, nf, no);
    issue(nr, nf, no);
    n = 1;
    wait_ack(n);
    chk("R6 verdict", req_err, !lg);
    if (lg) begin
      chk("R5 latency", n, LAT_OK);
      chk("R5 mode", pll_mode, 1);
      chk("R3 div word", pll_cfg_div, ((nr - 1) << 8) | (no - 1));
      chk("R3 fb word", pll_cfg_fb, nf - 1);
      chk("R3 bw word", pll_cfg_bw, nf / 2 - 1);
    end else begin
      chk("R7 latency", n, 1);
      chk("R7 div kept", pll_cfg_div, old_div);
      chk("R7 fb kept", pll_cfg_fb, old_fb);
      chk("R7 bw kept", pll_cfg_bw, old_bw);
      chk("R7 mode kept", pll_mode, old_mode);
    end
    @(negedge clk);
    chk("R10 ack pulse", req_ack, 0);
    chk("R10 err clear", req_err, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_total++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
    end
  end

  initial begin
    int n;
    int acks;
    rst_n = 1'b0;
    req_valid = 1'b0;
    req_ref_div = '0;
    req_fb_mul = '0;
    req_out_div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode", pll_mode, 0);
    chk("R1 div", pll_cfg_div, 0);
    chk("R1 fb", pll_cfg_fb, 0);
    chk("R1 bw", pll_cfg_bw, 0);
    chk("R1 ctl", pll_cfg_ctl, 0);
    chk("R1 ack", req_ack, 0);
    chk("R1 busy", req_busy, 0);

    run_check(1, 50, 2);

    // R2 / R4: cycle-exact ordering of one reprogramming
    issue(2, 80, 4);
    n = 1;
    chk("R2 bypass first", pll_mode, 0);
    chk("R2 reset not yet", pll_cfg_ctl[5], 0);
    chk("R9 busy", req_busy, 1);
    @(negedge clk); n++;
    chk("R2 reset second", pll_cfg_ctl[5], 1);
    chk("R2 div not yet", pll_cfg_div, 1);
    @(negedge clk); n++;
    chk("R2 div written", pll_cfg_div, (1 << 8) | 3);
    chk("R2 fb written", pll_cfg_fb, 79);
    chk("R2 bw written", pll_cfg_bw, 39);
    chk("R2 reset held", pll_cfg_ctl[5], 1);
    while (n < 2 + SETTLE) begin @(negedge clk); n++; end
    chk("R4 reset before release", pll_cfg_ctl[5], 1);
    @(negedge clk); n++;
    chk("R4 reset released", pll_cfg_ctl[5], 0);
    chk("R4 still bypass", pll_mode, 0);
    wait_ack(n);
    chk("R5 ack cycle", n, LAT_OK);
    chk("R5 no err", req_err, 0);
    chk("R5 running", pll_mode, 1);

    // R6: output divider sweep
    for (int no = 0; no <= 20; no++) run_check(1, 50, no);
    // R6: feedback sweep across both VCO edges
    for (int nf = 0; nf <= 100; nf++) run_check(1, nf, 2);
    // R6: reference divider sweep
    for (int nr = 0; nr <= 70; nr++) run_check(nr, 60, 1);
    run_check(64, 1200, 1);
    run_check(65, 1200, 1);
    run_check(1, 8193, 1);

    // R8: lock never arrives
    lock_dead = 1'b1;
    issue(1, 45, 2);
    n = 1;
    wait_ack(n);
    chk("R8 timeout cycle", n, LAT_TMO);
    chk("R8 err", req_err, 1);
    chk("R8 bypass kept", pll_mode, 0);
    chk("R8 reset low", pll_cfg_ctl[5], 0);
    chk("R8 fb applied", pll_cfg_fb, 44);
    lock_dead = 1'b0;
    run_check(1, 60, 4);

    // R9: request during a sequence is ignored
    issue(1, 40, 2);
    n = 1;
    while (n < 4) begin @(negedge clk); n++; end
    req_valid = 1'b1;
    req_ref_div = 7'd1; req_fb_mul = 14'd70; req_out_div = 5'd2;
    @(negedge clk); n++;
    req_valid = 1'b0;
    wait_ack(n);
    chk("R9 first completes", n, LAT_OK);
    chk("R9 first fb kept", pll_cfg_fb, 39);
    acks = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (req_ack) acks++;
    end
    chk("R9 no second ack", acks, 0);
    chk("R9 idle", req_busy, 0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", n_total - n_fail, n_total);
    $finish;
  end

endmodule